// File: doc/BRIEF.md
# Segment Selector Loader with Hidden Descriptor Cache

The block holds a small file of segment registers: six segment slots (slot 0 is the code slot, slots 1 to 5 are data slots) and a seventh slot, the local-table register. Each slot keeps the 16-bit selector last written to it, next to a hidden cache entry holding the segment's base, expanded limit, rights byte and default-size flag. The cache is refreshed only when a selector is written. Every later address check reads the cached values through the query port, with no memory access.

Writing a selector starts a multi-cycle table walk. The selector is split into a descriptor index, a table-select bit and a requested privilege level. The descriptor address is formed from the global table base (given on input pins) or from the local table base (taken from the cached local-table slot). That address is checked against the table's limit. The 8-byte descriptor is then fetched over a 64-bit read port, validated, and committed to the cache. For code and data descriptors the accessed bit is written back to memory when it is still clear.

The controller steps through six named states. IDLE waits for a selector write. ADDR decodes the selector, takes the null and table faults, and forms the address and limit check. READ holds the memory request until it is acknowledged. CHECK validates the descriptor. WRBACK writes the descriptor back with the accessed bit set. DONE raises the completion pulse. The transitions are:
- IDLE→ADDR on an accepted write.
- ADDR→DONE for a null selector or any address fault; ADDR→READ otherwise.
- READ→CHECK on acknowledge.
- CHECK→DONE on a validation fault or when no write-back is needed; CHECK→WRBACK otherwise.
- WRBACK→DONE on acknowledge.
- DONE→IDLE always.

Top module: `seg_desc_loader`

## Requirements
- R1: A selector is decoded as index = bits 15:3, table select = bit 2 (0 global, 1 local) and requested privilege = bits 1:0. The descriptor address is table base + index*8. The global base comes from `glob_base`. The local base is the cached base of slot 6.
- R2: If index*8+7 exceeds the selected table limit, the load faults without any memory access. The global limit is `glob_limit`, zero-extended. The local limit is the cached expanded limit of slot 6.
- R3: A local-table (bit 2 = 1) selector faults without memory access when it is written to slot 6, or when slot 6 holds no valid entry.
- R4: A descriptor read drives `mem_req`=1 and `mem_we`=0 and holds `mem_addr` stable until `mem_ack`. `mem_rdata` is taken in the cycle `mem_ack` is high.
- R5: A committed entry is filled as follows. Base = {d[63:56], d[39:16]}. Raw limit = {d[51:48], d[15:0]}; the limit is {raw, 12'hFFF} when G = d[55] is 1, and the raw value otherwise. Rights = d[47:40], with bit 0 forced to 1 for slots 0 to 5. Default size = d[54]. Valid = 1, and the selector is stored.
- R6: A load into slot 0 to 5 needs P = d[47] = 1 and S = d[44] = 1 (code/data). Otherwise it faults and that slot's entry is left as it was.
- R7: A successful load into slot 0 to 5 with d[40] = 0 writes the descriptor back to the same address with bit 40 set (`mem_req`=1, `mem_we`=1, held until `mem_ack`). With d[40] = 1 there is no write.
- R8: A load into slot 6 needs S = 0, type d[43:40] = 4'b0010 and P = 1. Otherwise it faults and slot 6 is unchanged. Slot 6 never causes a write-back.
- R9: A null selector (bits 15:2 all zero) written to slots 1 to 5 stores the selector with valid, base, limit, rights and size cleared, with no memory access and no fault. Written to slot 0 or 6 it faults.
- R10: `busy` is high from the cycle after an accepted write until the end of the single-cycle `done` pulse. `fault` is valid with `done`. `ld_valid` while `busy` is ignored. A slot number of 7 or more faults.
- R11: The query port shows slot `q_reg` combinationally. A slot's entry changes only when a load into it completes without fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ld_valid | input | 1 | Selector write strobe |
| ld_reg | input | 3 | Target slot (0 code, 1-5 data, 6 local table) |
| ld_sel | input | 16 | Selector value |
| glob_base | input | 32 | Global table base |
| glob_limit | input | 16 | Global table limit |
| busy | output | 1 | Load in progress |
| done | output | 1 | Load complete pulse |
| fault | output | 1 | Load rejected, valid with done |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write (accessed-bit write-back) |
| mem_addr | output | 32 | Descriptor byte address |
| mem_wdata | output | 64 | Write-back descriptor |
| mem_rdata | input | 64 | Read descriptor |
| mem_ack | input | 1 | Memory acknowledge |
| q_reg | input | 3 | Query slot |
| q_valid | output | 1 | Cached entry valid |
| q_sel | output | 16 | Cached selector |
| q_base | output | 32 | Cached base |
| q_limit | output | 32 | Cached expanded limit |
| q_rights | output | 8 | Cached rights byte |
| q_dsz | output | 1 | Cached default-size flag |

## Verification
A new selector write can arrive in the same cycle as a memory acknowledge, a write-back or the DONE pulse of a load already in progress. The bench provokes this by toggling `ld_valid` with unrelated selectors on random cycles during every walk, while the memory model acknowledges after a random delay. Each outcome is judged three ways: the number of reads and writes seen on the memory port, the fault flag, and all seven cache entries read back through the query port. All three must match a bench model that applied only the first write.

// File: rtl/seg_desc_pkg.sv
package seg_desc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_READ,
        ST_CHECK,
        ST_WRBACK,
        ST_DONE
    } ld_state_t;

    typedef struct packed {
        logic        valid;
        logic [15:0] sel;
        logic [31:0] base;
        logic [31:0] limit;
        logic [7:0]  rights;
        logic        dsz;
    } seg_entry_t;

    localparam int unsigned ABIT = 40;
    localparam int unsigned SBIT = 44;
    localparam int unsigned PBIT = 47;
    localparam int unsigned DBIT = 54;
    localparam int unsigned GBIT = 55;
    localparam logic [3:0]  LDT_TYPE = 4'b0010;

endpackage

// File: rtl/desc_check.sv
module desc_check
    import seg_desc_pkg::*;
(
    input  logic [63:0] desc,
    input  logic        is_ldt,
    input  logic [15:0] sel,
    output logic        ok,
    output logic        need_wb,
    output seg_entry_t  ent
);
    logic [19:0] raw_lim;

    always_comb begin
        raw_lim = {desc[51:48], desc[15:0]};
        if (is_ldt) begin
            ok = !desc[SBIT] && (desc[43:40] == LDT_TYPE) && desc[PBIT];
        end else begin
            ok = desc[SBIT] && desc[PBIT];
        end
        need_wb    = !is_ldt && !desc[ABIT];
        ent.valid  = 1'b1;
        ent.sel    = sel;
        ent.base   = {desc[63:56], desc[39:16]};
        ent.limit  = desc[GBIT] ? {raw_lim, 12'hFFF} : {12'h000, raw_lim};
        ent.rights = desc[47:40] | {7'b0, !is_ldt};
        ent.dsz    = desc[DBIT];
    end
endmodule

// File: rtl/seg_cache.sv
module seg_cache
    import seg_desc_pkg::*;
#(
    parameter int NREG = 7,
    localparam int RW = $clog2(NREG + 1)
)(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [RW-1:0] wr_idx,
    input  seg_entry_t    wr_ent,
    input  logic [RW-1:0] rd_idx,
    output seg_entry_t    rd_ent,
    output seg_entry_t    ldt_ent
);
    seg_entry_t slots [NREG];

    for (genvar i = 0; i < NREG; i++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slots[i] <= '0;
            end else if (wr_en && (wr_idx == RW'(i))) begin
                slots[i] <= wr_ent;
            end
        end
    end

    always_comb begin
        rd_ent = '0;
        for (int j = 0; j < NREG; j++) begin
            if (rd_idx == RW'(j)) rd_ent = slots[j];
        end
        ldt_ent = slots[NREG-1];
    end

    p_wr_idx_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (int'(wr_idx) < NREG));
endmodule

// File: rtl/seg_desc_loader.sv
module seg_desc_loader
    import seg_desc_pkg::*;
#(
    parameter int NSEG = 6,
    localparam int NREG = NSEG + 1,
    localparam int RW = $clog2(NREG + 1)
)(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_valid,
    input  logic [RW-1:0] ld_reg,
    input  logic [15:0]   ld_sel,
    input  logic [31:0]   glob_base,
    input  logic [15:0]   glob_limit,
    output logic          busy,
    output logic          done,
    output logic          fault,
    output logic          mem_req,
    output logic          mem_we,
    output logic [31:0]   mem_addr,
    output logic [63:0]   mem_wdata,
    input  logic [63:0]   mem_rdata,
    input  logic          mem_ack,
    input  logic [RW-1:0] q_reg,
    output logic          q_valid,
    output logic [15:0]   q_sel,
    output logic [31:0]   q_base,
    output logic [31:0]   q_limit,
    output logic [7:0]    q_rights,
    output logic          q_dsz
);
    ld_state_t     st, st_nx;
    logic [RW-1:0] cur_reg;
    logic [15:0]   cur_sel;
    logic [63:0]   desc_q;
    logic [31:0]   addr_q;
    logic          fault_q;

    seg_entry_t    rd_ent, ldt_ent, chk_ent, wr_ent;
    logic          wr_en, chk_ok, chk_wb;

    logic          is_ldt, is_data, is_null, ti, bad_reg, bad_tab, over_lim;
    logic [31:0]   off32, tbase, tlim;

    always_comb begin
        is_ldt   = (cur_reg == RW'(NSEG));
        is_data  = (cur_reg != '0) && (int'(cur_reg) < NSEG);
        bad_reg  = (int'(cur_reg) >= NREG);
        is_null  = (cur_sel[15:2] == 14'd0);
        ti       = cur_sel[2];
        off32    = {16'd0, cur_sel[15:3], 3'b000};
        tbase    = ti ? ldt_ent.base  : glob_base;
        tlim     = ti ? ldt_ent.limit : {16'd0, glob_limit};
        bad_tab  = ti && (is_ldt || !ldt_ent.valid);
        over_lim = ({1'b0, off32} + 33'd7) > {1'b0, tlim};
    end

    desc_check u_chk (
        .desc    (desc_q),
        .is_ldt  (is_ldt),
        .sel     (cur_sel),
        .ok      (chk_ok),
        .need_wb (chk_wb),
        .ent     (chk_ent)
    );

    // next state
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE:   if (ld_valid) st_nx = ST_ADDR;
            ST_ADDR:   begin
                if (bad_reg || is_null || bad_tab || over_lim) st_nx = ST_DONE;
                else st_nx = ST_READ;
            end
            ST_READ:   if (mem_ack) st_nx = ST_CHECK;
            ST_CHECK:  begin
                if (!chk_ok) st_nx = ST_DONE;
                else if (chk_wb) st_nx = ST_WRBACK;
                else st_nx = ST_DONE;
            end
            ST_WRBACK: if (mem_ack) st_nx = ST_DONE;
            ST_DONE:   st_nx = ST_IDLE;
            default:   st_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // walk datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_reg <= '0;
            cur_sel <= '0;
            desc_q  <= '0;
            addr_q  <= '0;
            fault_q <= 1'b0;
        end else begin
            unique case (st)
                ST_IDLE: if (ld_valid) begin
                    cur_reg <= ld_reg;
                    cur_sel <= ld_sel;
                    fault_q <= 1'b0;
                end
                ST_ADDR: begin
                    addr_q  <= tbase + off32;
                    fault_q <= bad_reg || (is_null && !is_data) ||
                               (!is_null && (bad_tab || over_lim));
                end
                ST_READ:   if (mem_ack) desc_q <= mem_rdata;
                ST_CHECK:  fault_q <= !chk_ok;
                ST_WRBACK: ;
                ST_DONE:   ;
                default:   ;
            endcase
        end
    end

    // outputs and cache commit
    always_comb begin
        busy      = (st != ST_IDLE);
        done      = (st == ST_DONE);
        fault     = done && fault_q;
        mem_req   = (st == ST_READ) || (st == ST_WRBACK);
        mem_we    = (st == ST_WRBACK);
        mem_addr  = addr_q;
        mem_wdata = desc_q | (64'd1 << ABIT);
        wr_en     = 1'b0;
        wr_ent    = chk_ent;
        unique case (st)
            ST_ADDR: if (!bad_reg && is_null && is_data) begin
                wr_en      = 1'b1;
                wr_ent     = '0;
                wr_ent.sel = cur_sel;
            end
            ST_CHECK:  wr_en = chk_ok && !chk_wb;
            ST_WRBACK: wr_en = mem_ack;
            default:   ;
        endcase
    end

    seg_cache #(.NREG(NREG)) u_cache (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (cur_reg),
        .wr_ent  (wr_ent),
        .rd_idx  (q_reg),
        .rd_ent  (rd_ent),
        .ldt_ent (ldt_ent)
    );

    assign q_valid  = rd_ent.valid;
    assign q_sel    = rd_ent.sel;
    assign q_base   = rd_ent.base;
    assign q_limit  = rd_ent.limit;
    assign q_rights = rd_ent.rights;
    assign q_dsz    = rd_ent.dsz;

    p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
    p_wb_abit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> mem_wdata[ABIT]);
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));
    p_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && !busy) |=> busy);
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);
    p_ldt_no_wb_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && mem_req) |-> (cur_reg != RW'(NSEG)));
endmodule

// File: tb/seg_desc_loader_tb.sv
module seg_desc_loader_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_valid = 1'b0;
    logic [2:0]  ld_reg = '0;
    logic [15:0] ld_sel = '0;
    logic [31:0] glob_base = 32'h0000_0800;
    logic [15:0] glob_limit = 16'h00FF;
    logic        busy, done, fault, mem_req, mem_we;
    logic [31:0] mem_addr;
    logic [63:0] mem_wdata;
    logic [63:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;
    logic [2:0]  q_reg = '0;
    logic        q_valid, q_dsz;
    logic [15:0] q_sel;
    logic [31:0] q_base, q_limit;
    logic [7:0]  q_rights;

    always #2.5 clk = ~clk;

    seg_desc_loader u_dut (
        .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_reg(ld_reg),
        .ld_sel(ld_sel), .glob_base(glob_base), .glob_limit(glob_limit),
        .busy(busy), .done(done), .fault(fault), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack), .q_reg(q_reg),
        .q_valid(q_valid), .q_sel(q_sel), .q_base(q_base), .q_limit(q_limit),
        .q_rights(q_rights), .q_dsz(q_dsz)
    );

    int checks = 0;
    int errors = 0;
    int n_rd = 0;
    int n_wr = 0;
    logic [63:0] mem [512];

    // memory model: random-latency acknowledge
    always @(posedge clk) begin
        mem_rdata <= mem[int'(mem_addr[11:3])];
        mem_ack   <= mem_req && !mem_ack && ($urandom % 2 == 0);
        if (mem_req && mem_ack) begin
            if (mem_we) begin
                mem[int'(mem_addr[11:3])] <= mem_wdata;
                n_wr <= n_wr + 1;
            end else begin
                n_rd <= n_rd + 1;
            end
        end
    end

    // bench model of the cache
    logic        ev [7];
    logic [15:0] esel [7];
    logic [31:0] ebase [7];
    logic [31:0] elim [7];
    logic [7:0]  erts [7];
    logic        edsz [7];

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] mk_desc(input logic [31:0] b, input logic [19:0] l,
                                            input logic [7:0] ar, input logic g, input logic d);
        return {b[31:24], g, d, 2'b00, l[19:16], ar, b[23:0], l[15:0]};
    endfunction

    function automatic logic [63:0] rnd_desc();
        logic [63:0] dsc;
        dsc = {$urandom, $urandom};
        dsc[47] = ($urandom % 5 != 0);
        dsc[44] = ($urandom % 5 != 0);
        if (!dsc[44] && dsc[43:40] == 4'b0010) dsc[43:40] = 4'b0011;
        return dsc;
    endfunction

    task automatic cmp_all(input string req);
        for (int i = 0; i < 7; i++) begin
            q_reg = 3'(i);
            #0.5;
            chk(req, $sformatf("slot%0d entry", i),
                {q_valid, q_sel, q_base, q_rights, q_dsz},
                {ev[i], esel[i], ebase[i], erts[i], edsz[i]});
            chk(req, $sformatf("slot%0d limit", i), q_limit, elim[i]);
        end
    endtask

    // one load, with junk writes while busy (R10) and full prediction
    task automatic run_load(input int r, input logic [15:0] s, input string req);
        logic ef, ewb, is_null, ti, dat;
        int erd, rd0, wr0, cyc, idx;
        logic [31:0] off, tb, tl;
        logic [63:0] d;
        ef = 0; ewb = 0; erd = 0; idx = 0; d = '0;
        is_null = (s[15:2] == 0); ti = s[2]; dat = (r >= 1 && r <= 5);
        off = {16'd0, s[15:3], 3'b000};
        if (r > 6) ef = 1;
        else if (is_null) ef = !dat;
        else if (ti && (r == 6 || !ev[6])) ef = 1;
        else begin
            tb = ti ? ebase[6] : glob_base;
            tl = ti ? elim[6] : {16'd0, glob_limit};
            if ({1'b0, off} + 33'd7 > {1'b0, tl}) ef = 1;
            else begin
                erd = 1;
                idx = int'(((tb + off) >> 3) & 32'h1FF);
                d = mem[idx];
                if (r == 6) ef = !(!d[44] && d[43:40] == 4'b0010 && d[47]);
                else ef = !(d[47] && d[44]);
                ewb = !ef && r != 6 && !d[40];
            end
        end
        rd0 = n_rd; wr0 = n_wr;
        @(negedge clk);
        ld_valid = 1; ld_reg = 3'(r); ld_sel = s;
        @(negedge clk);
        chk("R10", "busy after accept", busy, 1);
        cyc = 0;
        while (!done && cyc < 200) begin
            ld_valid = ($urandom % 3 == 0); ld_reg = 3'($urandom); ld_sel = 16'($urandom);
            @(negedge clk);
            cyc++;
        end
        ld_valid = 0;
        chk(req, "fault", fault, ef);
        @(negedge clk);
        chk("R10", "idle after done", {busy, done}, 0);
        chk("R4", "reads", n_rd - rd0, erd);
        chk("R7", "writes", n_wr - wr0, ewb);
        if (ewb) chk("R7", "written descriptor", mem[idx], d | (64'd1 << 40));
        if (!ef && r <= 6) begin
            esel[r] = s;
            if (is_null) begin
                ev[r] = 0; ebase[r] = 0; elim[r] = 0; erts[r] = 0; edsz[r] = 0;
            end else begin
                ev[r] = 1;
                ebase[r] = {d[63:56], d[39:16]};
                elim[r] = d[55] ? {d[51:48], d[15:0], 12'hFFF} : {12'd0, d[51:48], d[15:0]};
                erts[r] = d[47:40] | {7'd0, r != 6};
                edsz[r] = d[54];
            end
        end
        cmp_all(req);
    endtask

    initial begin
        int wd = 0;
        forever begin
            @(posedge clk);
            wd++;
            if (wd > 150000) begin
                errors++;
                checks++;
                $display("FAIL watchdog: actual timeout expected completion");
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < 512; i++) mem[i] = rnd_desc();
        for (int i = 0; i < 7; i++) begin
            ev[i] = 0; esel[i] = 0; ebase[i] = 0; elim[i] = 0; erts[i] = 0; edsz[i] = 0;
        end
        // local tables at 0xC00 (16 entries) and 0xE00 (8 entries)
        mem[256 + 5] = mk_desc(32'h0000_0C00, 20'h0007F, 8'h82, 0, 0);
        mem[256 + 6] = mk_desc(32'h0000_0E00, 20'h0003F, 8'h82, 0, 0);
        mem[256 + 7] = mk_desc(32'h0000_0C00, 20'h0007F, 8'h02, 0, 0);
        mem[256 + 3] = mk_desc(32'h1234_5678, 20'h0ABCD, 8'h12, 0, 1);
        mem[256 + 9] = mk_desc(32'h0010_0000, 20'h00FFF, 8'h92, 1, 1);
        mem[256 + 10] = mk_desc(32'h0020_0000, 20'h00010, 8'h9B, 0, 0);
        mem[256 + 31] = mk_desc(32'h0030_0000, 20'h00020, 8'h93, 0, 1);
        mem[384 + 2] = mk_desc(32'h0040_0000, 20'h00100, 8'h92, 0, 0);
        #12;
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R10", "reset outputs", {busy, done, fault, mem_req}, 0);
        cmp_all("R11");
        // directed corner cases
        run_load(2, 16'h0018 | 16'h0004, "R3");        // local select with no local table
        run_load(6, {13'd7, 3'b000}, "R8");             // not present local-table descriptor
        run_load(6, {13'd5, 3'b011}, "R8");             // valid local-table descriptor
        run_load(6, {13'd3, 3'b000}, "R8");             // code/data descriptor into local slot
        run_load(6, {13'd1, 3'b100}, "R3");             // local select into local slot
        run_load(1, {13'd3, 3'b000}, "R6");             // P=0
        run_load(1, {13'd9, 3'b001}, "R5");             // G=1, write-back
        run_load(1, {13'd9, 3'b001}, "R7");             // A already set: no write
        run_load(0, {13'd10, 3'b000}, "R5");            // code slot
        run_load(3, {13'd31, 3'b000}, "R2");            // last entry inside limit
        run_load(3, {13'd32, 3'b000}, "R2");            // first entry beyond limit
        run_load(4, {13'd2, 3'b110}, "R1");             // local table lookup
        run_load(4, {13'd16, 3'b100}, "R2");            // beyond local limit
        run_load(5, 16'h0003, "R9");                    // null into data slot
        run_load(0, 16'h0002, "R9");                    // null into code slot
        run_load(6, 16'h0000, "R9");                    // null into local slot
        run_load(7, {13'd9, 3'b000}, "R10");            // out-of-range slot
        // constrained random
        for (int n = 0; n < 400; n++) begin
            int r;
            logic [15:0] s;
            r = ($urandom % 8 == 0) ? 6 : int'($urandom % 6);
            s = {13'($urandom % 40), 1'($urandom), 2'($urandom)};
            if ($urandom % 10 == 0) s[15:2] = '0;
            if (r == 6 && $urandom % 2 == 0) s = {13'(5 + $urandom % 2), 3'($urandom % 4)};
            if ($urandom % 20 == 0) mem[256 + int'($urandom % 32)] = rnd_desc();
            mem[261] = mk_desc(32'h0000_0C00, 20'h0007F, 8'h82, 0, 0);
            mem[262] = mk_desc(32'h0000_0E00, 20'h0003F, 8'h82, 0, 0);
            run_load(r, s, "R1");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule